// File: doc/BRIEF.md
# Interrupt, Bus-Grant and Reset Sequencer

This block is the part of a small processor's control unit that decides, at each boundary, what the core does next. It can hand the bus to an external master, enter the non-maskable interrupt handler, enter the maskable interrupt handler, jump to a restart slot, or let execution continue. The core sends it end-of-machine-cycle and end-of-instruction strobes, its halt state, and decoded commands for enabling and disabling interrupts, setting the interrupt mode and executing restart instructions. It also receives the raw active-low bus request, NMI, INT and RESET lines.

When the block chooses a new program address it raises a one-cycle vector strobe. The strobe carries the 16-bit target and a source code that says why the jump happened. Bus grants are decided at machine-cycle ends. Interrupts are decided at instruction ends, and also on every cycle while the core is halted. In interrupt modes 0 and 2 the block only acknowledges the interrupt. The vector fetch is left to external logic.

Top module: `irq_bus_seq`

## Requirements
- R1: After `reset_n` has been sampled low on RST_MIN_CLKS consecutive rising edges, the next edge clears both enable flops, the interrupt mode (to 0), the bus grant and any latched NMI edge. A shorter low pulse has no effect on any of these.
- R2: On the first edge at which `reset_n` is high again after a completed reset, the block emits one vector strobe with source 0 (reset) and address 0x0000.
- R3: `busack` rises only after an edge where `mc_end` is 1 and `busreq_n` is 0. It stays high while `busreq_n` stays low, and drops one edge after `busreq_n` goes high. A low `busreq_n` without `mc_end` does not grant the bus.
- R4: While the bus is granted, or at an edge that grants it, no interrupt is accepted. A latched NMI stays pending and is taken at a later boundary.
- R5: A falling edge on `nmi_n` is latched. At the next boundary it is taken whatever the enable flops hold, with source 2 and address 0x0066. One edge produces exactly one entry, and a pending NMI wins over INT.
- R6: Taking an NMI copies `iff1` into `iff2` and clears `iff1`.
- R7: A low `int_n` is accepted at a boundary only when `iff1` is 1 and no NMI is pending. Acceptance clears both flops. In mode 1 it emits source 3 and address 0x0038.
- R8: In modes 0 and 2 an accepted INT pulses `int_ext_ack` for one cycle and emits no vector strobe. The two outputs are never high together.
- R9: `cmd_ei` sets both flops and `cmd_di` clears both. An interrupt accepted at the same edge overrides the command.
- R10: `cmd_im_we` loads mode 0, 1 or 2 from `cmd_im`. The code 3 leaves the mode unchanged.
- R11: A restart strobe with slot n (0 to 7) emits source 1 and address n×8. An interrupt accepted at the same edge wins, and no restart vector is emitted.
- R12: While `halted` is 1, every cycle counts as a boundary. `halt_release` pulses together with the acceptance of an NMI or an enabled INT, and never when the core was not halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| reset_n | input | 1 | Raw reset request, active low, filtered by length |
| busreq_n | input | 1 | External bus request, active low |
| nmi_n | input | 1 | Non-maskable interrupt, falling-edge sensitive |
| int_n | input | 1 | Maskable interrupt level, active low |
| mc_end | input | 1 | Last cycle of a machine cycle |
| instr_end | input | 1 | Last cycle of an instruction |
| halted | input | 1 | Core is in the halt state |
| cmd_ei | input | 1 | Enable-interrupts command |
| cmd_di | input | 1 | Disable-interrupts command |
| cmd_im_we | input | 1 | Interrupt-mode write strobe |
| cmd_im | input | 2 | Interrupt mode to write |
| rst_instr | input | 1 | Restart instruction strobe |
| rst_num | input | 3 | Restart slot number |
| busack | output | 1 | Bus granted to the external master |
| vec_valid | output | 1 | One-cycle new-target strobe |
| vec_src | output | 2 | Jump cause: 0 reset, 1 restart, 2 NMI, 3 INT |
| vec_addr | output | 16 | Jump target address |
| int_ext_ack | output | 1 | INT accepted in mode 0 or 2 |
| halt_release | output | 1 | Leave the halt state |
| iff1 | output | 1 | Interrupt enable flop |
| iff2 | output | 1 | Saved enable flop, for readback |
| im_mode | output | 2 | Current interrupt mode |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a three-clock reset filter, an NMI input with no synchroniser stages and 8-byte restart slots. With no synchroniser, an NMI edge becomes pending after a single clock. This lets the bench line up an edge, a bus request, a halt and an instruction end on the same edge, so every priority collision can be tested. Because the reset filter is short, the bench can also reach both a two-clock pulse that must be ignored and a full reset that must also drop a pending NMI.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   typedef enum logic [1:0] {
      SRC_RESET = 2'd0,
      SRC_RST   = 2'd1,
      SRC_NMI   = 2'd2,
      SRC_INT   = 2'd3
   } vec_src_e;

   typedef struct packed {
      logic grant;
      logic take_nmi;
      logic take_int;
      logic take_rst;
   } decision_t;

   localparam logic [1:0] MODE_VECTORED_FIXED = 2'd1;
   localparam logic [1:0] MODE_RESERVED       = 2'd3;

endpackage

// File: rtl/irq_rst_filter.sv
module irq_rst_filter #(
   parameter int MIN_LOW = 3
) (
   input  logic clk,
   input  logic reset_n,
   output logic in_reset,
   output logic leaving
);
   localparam int CW = $clog2(MIN_LOW + 1);
   localparam logic [CW-1:0] FULL = CW'(MIN_LOW);

   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk) begin
      if (reset_n)
         low_cnt <= '0;
      else if (low_cnt != FULL)
         low_cnt <= low_cnt + 1'b1;
   end

   assign in_reset = (low_cnt == FULL);
   assign leaving  = in_reset & reset_n;

endmodule

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic in_reset,
   input  logic nmi_n,
   input  logic accept,
   output logic pending
);
   logic nmi_s;
   logic nmi_prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign nmi_s = nmi_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (in_reset)
               chain <= '1;
            else
               chain <= {chain[SYNC_STAGES-2:0], nmi_n};
         end
         assign nmi_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   logic fall;
   assign fall = nmi_prev & ~nmi_s;

   always_ff @(posedge clk) begin
      if (in_reset) begin
         nmi_prev <= 1'b1;
         pending  <= 1'b0;
      end else begin
         nmi_prev <= nmi_s;
         pending  <= fall | (pending & ~accept);
      end
   end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_seq_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter int          RST_SLOT = 8,
   parameter logic [15:0] NMI_VEC  = 16'h0066,
   parameter logic [15:0] INT_VEC  = 16'h0038
) (
   input  logic              instr_end,
   input  logic              halted,
   input  logic              mc_end,
   input  logic              busreq_n,
   input  logic              busack,
   input  logic              nmi_pend,
   input  logic              iff1,
   input  logic              int_n,
   input  logic              rst_instr,
   input  logic [2:0]        rst_num,
   input  logic [1:0]        im_mode,
   output decision_t         dec,
   output vec_src_e          src,
   output logic [ADDR_W-1:0] addr,
   output logic              emit_vec,
   output logic              ext_ack
);
   localparam int SLOT_SH = $clog2(RST_SLOT);

   logic boundary;
   logic blocked;
   logic [ADDR_W-1:0] rst_addr;

   assign boundary = instr_end | halted;
   assign dec.grant = mc_end & ~busreq_n & ~busack;
   assign blocked  = busack | dec.grant;

   assign dec.take_nmi = boundary & ~blocked & nmi_pend;
   assign dec.take_int = boundary & ~blocked & ~nmi_pend & iff1 & ~int_n;
   assign dec.take_rst = rst_instr & ~blocked & ~dec.take_nmi & ~dec.take_int;

   generate
      if (SLOT_SH == 0) begin : g_byte_slot
         assign rst_addr = ADDR_W'(rst_num);
      end else begin : g_wide_slot
         assign rst_addr = ADDR_W'(rst_num) << SLOT_SH;
      end
   endgenerate

   always_comb begin
      src      = SRC_RST;
      addr     = rst_addr;
      emit_vec = 1'b0;
      ext_ack  = 1'b0;
      if (dec.take_nmi) begin
         src      = SRC_NMI;
         addr     = ADDR_W'(NMI_VEC);
         emit_vec = 1'b1;
      end else if (dec.take_int) begin
         src  = SRC_INT;
         addr = ADDR_W'(INT_VEC);
         if (im_mode == MODE_VECTORED_FIXED)
            emit_vec = 1'b1;
         else
            ext_ack = 1'b1;
      end else if (dec.take_rst) begin
         emit_vec = 1'b1;
      end
   end

endmodule

// File: rtl/irq_bus_seq.sv
module irq_bus_seq
   import irq_seq_pkg::*;
#(
   parameter int          ADDR_W          = 16,
   parameter int          RST_MIN_CLKS    = 3,
   parameter int          NMI_SYNC_STAGES = 0,
   parameter int          RST_SLOT        = 8,
   parameter logic [15:0] NMI_VEC         = 16'h0066,
   parameter logic [15:0] INT_VEC         = 16'h0038
) (
   input  logic              clk,
   input  logic              reset_n,
   input  logic              busreq_n,
   input  logic              nmi_n,
   input  logic              int_n,
   input  logic              mc_end,
   input  logic              instr_end,
   input  logic              halted,
   input  logic              cmd_ei,
   input  logic              cmd_di,
   input  logic              cmd_im_we,
   input  logic [1:0]        cmd_im,
   input  logic              rst_instr,
   input  logic [2:0]        rst_num,
   output logic              busack,
   output logic              vec_valid,
   output logic [1:0]        vec_src,
   output logic [ADDR_W-1:0] vec_addr,
   output logic              int_ext_ack,
   output logic              halt_release,
   output logic              iff1,
   output logic              iff2,
   output logic [1:0]        im_mode
);
   localparam int SLOT_TOP = RST_SLOT * 8;

   generate
      if (RST_MIN_CLKS < 1) begin : g_bad_rst
         $error("RST_MIN_CLKS must be at least 1");
      end
      if (NMI_SYNC_STAGES == 1 || NMI_SYNC_STAGES < 0) begin : g_bad_sync
         $error("NMI_SYNC_STAGES must be 0 or at least 2");
      end
      if ((RST_SLOT & (RST_SLOT - 1)) != 0 || RST_SLOT < 1) begin : g_bad_slot
         $error("RST_SLOT must be a power of two");
      end
      if (ADDR_W < 8 || SLOT_TOP > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for the restart slots");
      end
   endgenerate

   logic in_reset;
   logic leaving;
   logic nmi_pend;
   decision_t dec;
   vec_src_e  nxt_src;
   logic [ADDR_W-1:0] nxt_addr;
   logic nxt_emit;
   logic nxt_ext;

   irq_rst_filter #(.MIN_LOW(RST_MIN_CLKS)) u_rst (
      .clk      (clk),
      .reset_n  (reset_n),
      .in_reset (in_reset),
      .leaving  (leaving)
   );

   irq_nmi_edge #(.SYNC_STAGES(NMI_SYNC_STAGES)) u_nmi (
      .clk      (clk),
      .in_reset (in_reset),
      .nmi_n    (nmi_n),
      .accept   (dec.take_nmi),
      .pending  (nmi_pend)
   );

   irq_arbiter #(
      .ADDR_W   (ADDR_W),
      .RST_SLOT (RST_SLOT),
      .NMI_VEC  (NMI_VEC),
      .INT_VEC  (INT_VEC)
   ) u_arb (
      .instr_end (instr_end),
      .halted    (halted),
      .mc_end    (mc_end),
      .busreq_n  (busreq_n),
      .busack    (busack),
      .nmi_pend  (nmi_pend),
      .iff1      (iff1),
      .int_n     (int_n),
      .rst_instr (rst_instr),
      .rst_num   (rst_num),
      .im_mode   (im_mode),
      .dec       (dec),
      .src       (nxt_src),
      .addr      (nxt_addr),
      .emit_vec  (nxt_emit),
      .ext_ack   (nxt_ext)
   );

   // bus grant
   always_ff @(posedge clk) begin
      if (in_reset)
         busack <= 1'b0;
      else if (busack)
         busack <= ~busreq_n;
      else
         busack <= dec.grant;
   end

   // enable flops
   always_ff @(posedge clk) begin
      if (in_reset) begin
         iff1 <= 1'b0;
         iff2 <= 1'b0;
      end else if (dec.take_nmi) begin
         iff2 <= iff1;
         iff1 <= 1'b0;
      end else if (dec.take_int) begin
         iff1 <= 1'b0;
         iff2 <= 1'b0;
      end else if (cmd_ei) begin
         iff1 <= 1'b1;
         iff2 <= 1'b1;
      end else if (cmd_di) begin
         iff1 <= 1'b0;
         iff2 <= 1'b0;
      end
   end

   // interrupt mode
   always_ff @(posedge clk) begin
      if (in_reset)
         im_mode <= 2'd0;
      else if (cmd_im_we && cmd_im != MODE_RESERVED)
         im_mode <= cmd_im;
   end

   // vector and strobes
   always_ff @(posedge clk) begin
      if (in_reset) begin
         vec_valid    <= leaving;
         vec_src      <= SRC_RESET;
         vec_addr     <= '0;
         int_ext_ack  <= 1'b0;
         halt_release <= 1'b0;
      end else begin
         vec_valid    <= nxt_emit;
         vec_src      <= nxt_src;
         vec_addr     <= nxt_addr;
         int_ext_ack  <= nxt_ext;
         halt_release <= halted & (dec.take_nmi | dec.take_int);
      end
   end

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
   parameter int          ADDR_W  = 16,
   parameter logic [15:0] NMI_VEC = 16'h0066
) (
   input logic              clk,
   input logic              in_reset,
   input logic              busreq_n,
   input logic              mc_end,
   input logic              halted,
   input logic              busack,
   input logic              vec_valid,
   input logic [1:0]        vec_src,
   input logic [ADDR_W-1:0] vec_addr,
   input logic              int_ext_ack,
   input logic              halt_release,
   input logic              iff1,
   input logic              iff2,
   input logic [1:0]        im_mode
);
   logic seen = 1'b0;
   always_ff @(posedge clk) seen <= seen | in_reset;

   assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!seen)
      in_reset |=> (!iff1 && !iff2 && im_mode == 2'd0 && !busack));

   assert_reset_vector_R2: assert property (@(posedge clk) disable iff (!seen || in_reset)
      (vec_valid && vec_src == 2'd0) |-> (vec_addr == '0 && $past(in_reset)));

   assert_grant_cause_R3: assert property (@(posedge clk) disable iff (!seen || in_reset)
      $rose(busack) |-> $past(mc_end && !busreq_n));

   assert_no_vec_granted_R4: assert property (@(posedge clk) disable iff (!seen || in_reset)
      vec_valid |-> !busack);

   assert_nmi_target_R5: assert property (@(posedge clk) disable iff (!seen || in_reset)
      (vec_valid && vec_src == 2'd2) |-> vec_addr == ADDR_W'(NMI_VEC));

   assert_nmi_flops_R6: assert property (@(posedge clk) disable iff (!seen || in_reset)
      (vec_valid && vec_src == 2'd2) |-> (!iff1 && iff2 == $past(iff1)));

   assert_int_enabled_R7: assert property (@(posedge clk) disable iff (!seen || in_reset)
      (vec_valid && vec_src == 2'd3) |-> ($past(iff1) && !iff1 && !iff2));

   assert_ack_exclusive_R8: assert property (@(posedge clk) disable iff (!seen || in_reset)
      !(vec_valid && int_ext_ack));

   assert_release_halted_R12: assert property (@(posedge clk) disable iff (!seen || in_reset)
      halt_release |-> $past(halted));

endmodule

bind irq_bus_seq irq_seq_chk #(.ADDR_W(ADDR_W), .NMI_VEC(NMI_VEC)) u_chk (
   .clk          (clk),
   .in_reset     (in_reset),
   .busreq_n     (busreq_n),
   .mc_end       (mc_end),
   .halted       (halted),
   .busack       (busack),
   .vec_valid    (vec_valid),
   .vec_src      (vec_src),
   .vec_addr     (vec_addr),
   .int_ext_ack  (int_ext_ack),
   .halt_release (halt_release),
   .iff1         (iff1),
   .iff2         (iff2),
   .im_mode      (im_mode)
);

// File: tb/tb_irq_bus_seq.sv
module tb_irq_bus_seq;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic reset_n = 1'b0, busreq_n = 1'b1, nmi_n = 1'b1, int_n = 1'b1;
   logic mc_end = 1'b0, instr_end = 1'b0, halted = 1'b0;
   logic cmd_ei = 1'b0, cmd_di = 1'b0, cmd_im_we = 1'b0, rst_instr = 1'b0;
   logic [1:0] cmd_im = 2'd0;
   logic [2:0] rst_num = 3'd0;
   logic busack, vec_valid, int_ext_ack, halt_release, iff1, iff2;
   logic [1:0] vec_src, im_mode;
   logic [15:0] vec_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_bus_seq dut (
      .clk(clk), .reset_n(reset_n), .busreq_n(busreq_n), .nmi_n(nmi_n), .int_n(int_n),
      .mc_end(mc_end), .instr_end(instr_end), .halted(halted), .cmd_ei(cmd_ei),
      .cmd_di(cmd_di), .cmd_im_we(cmd_im_we), .cmd_im(cmd_im), .rst_instr(rst_instr),
      .rst_num(rst_num), .busack(busack), .vec_valid(vec_valid), .vec_src(vec_src),
      .vec_addr(vec_addr), .int_ext_ack(int_ext_ack), .halt_release(halt_release),
      .iff1(iff1), .iff2(iff2), .im_mode(im_mode)
   );

   typedef struct {
      logic [1:0]  src;
      logic [15:0] addr;
      string       req;
   } exp_t;

   exp_t sb[$];
   int total = 0;
   int bad = 0;
   bit done = 0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic expect_vec(logic [1:0] s, logic [15:0] a, string req);
      exp_t e;
      e.src = s; e.addr = a; e.req = req;
      sb.push_back(e);
   endtask

   task automatic step();
      @(posedge clk);
      #1;
      instr_end = 0; mc_end = 0; cmd_ei = 0; cmd_di = 0;
      cmd_im_we = 0; rst_instr = 0;
   endtask

   // monitor: every vector strobe must match the next expected item
   always @(negedge clk) begin
      if (vec_valid === 1'b1) begin
         if (sb.size() == 0) begin
            total++; bad++;
            $display("FAIL unexpected vector actual=%0d/%0h expected=none", vec_src, vec_addr);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk({e.req, " src"}, 32'(vec_src), 32'(e.src));
            chk({e.req, " addr"}, 32'(vec_addr), 32'(e.addr));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (4) step();
      chk("R1 iff1", 32'(iff1), 0); chk("R1 iff2", 32'(iff2), 0);
      chk("R1 busack", 32'(busack), 0); chk("R1 mode", 32'(im_mode), 0);
      // R2 reset vector
      expect_vec(2'd0, 16'h0000, "R2");
      reset_n = 1; step();
      step();
      chk("R2 single pulse", 32'(vec_valid), 0);

      // R10 mode writes
      cmd_im = 2'd1; cmd_im_we = 1; step(); chk("R10 mode1", 32'(im_mode), 1);
      cmd_im = 2'd3; cmd_im_we = 1; step(); chk("R10 code3 ignored", 32'(im_mode), 1);
      cmd_im = 2'd2; cmd_im_we = 1; step(); chk("R10 mode2", 32'(im_mode), 2);
      cmd_im = 2'd1; cmd_im_we = 1; step();

      // R9 enable
      cmd_ei = 1; step();
      chk("R9 ei iff1", 32'(iff1), 1); chk("R9 ei iff2", 32'(iff2), 1);

      // R1 short pulse ignored
      reset_n = 0; step(); step(); reset_n = 1; step(); step();
      chk("R1 short pulse", 32'(iff1), 1);

      // R7 INT in mode 1
      int_n = 0; instr_end = 1; expect_vec(2'd3, 16'h0038, "R7"); step();
      chk("R7 iff1 cleared", 32'(iff1), 0); chk("R7 iff2 cleared", 32'(iff2), 0);
      instr_end = 1; step();
      chk("R7 masked", 32'(iff1), 0);
      int_n = 1;

      // R5 R6 NMI with iff1 set
      cmd_ei = 1; step();
      nmi_n = 0; step();
      instr_end = 1; expect_vec(2'd2, 16'h0066, "R5"); step();
      chk("R6 iff1", 32'(iff1), 0); chk("R6 iff2", 32'(iff2), 1);
      instr_end = 1; step();   // no second entry (R5)
      nmi_n = 1; step();

      // R6 NMI with iff1 clear copies 0
      nmi_n = 0; step();
      instr_end = 1; expect_vec(2'd2, 16'h0066, "R5 masked"); step();
      chk("R6 copy zero", 32'(iff2), 0);
      nmi_n = 1; step();

      // R5 NMI beats INT
      cmd_ei = 1; step();
      int_n = 0; nmi_n = 0; step();
      instr_end = 1; expect_vec(2'd2, 16'h0066, "R5 priority"); step();
      chk("R5 priority iff1", 32'(iff1), 0);
      nmi_n = 1; int_n = 1; step();

      // R3 R4 bus grant
      cmd_ei = 1; step();
      busreq_n = 0; step();
      chk("R3 no grant without mc_end", 32'(busack), 0);
      mc_end = 1; step();
      chk("R3 grant", 32'(busack), 1);
      int_n = 0; instr_end = 1; step();
      chk("R4 int held off", 32'(iff1), 1);
      chk("R3 hold", 32'(busack), 1);
      int_n = 1; busreq_n = 1; step();
      chk("R3 release", 32'(busack), 0);

      // R4 grant beats NMI in the same cycle
      nmi_n = 0; step();
      busreq_n = 0; mc_end = 1; instr_end = 1; step();
      chk("R4 grant wins", 32'(busack), 1);
      chk("R4 nmi deferred", 32'(iff1), 1);
      busreq_n = 1; step();
      chk("R4 release", 32'(busack), 0);
      instr_end = 1; expect_vec(2'd2, 16'h0066, "R4 deferred nmi"); step();
      chk("R4 nmi taken later", 32'(iff1), 0);
      nmi_n = 1; step();

      // R11 restart slots
      rst_instr = 1; rst_num = 3'd5; expect_vec(2'd1, 16'h0028, "R11 n5"); step();
      rst_instr = 1; rst_num = 3'd0; expect_vec(2'd1, 16'h0000, "R11 n0"); step();
      rst_instr = 1; rst_num = 3'd7; expect_vec(2'd1, 16'h0038, "R11 n7"); step();
      cmd_ei = 1; step();
      int_n = 0; instr_end = 1; rst_instr = 1; rst_num = 3'd3;
      expect_vec(2'd3, 16'h0038, "R11 int wins"); step();
      int_n = 1; step();

      // R8 mode 0 external acknowledge
      cmd_im = 2'd0; cmd_im_we = 1; cmd_ei = 1; step();
      int_n = 0; instr_end = 1; step();
      chk("R8 ext ack", 32'(int_ext_ack), 1); chk("R8 iff1", 32'(iff1), 0);
      int_n = 1; step();
      chk("R8 ack pulse", 32'(int_ext_ack), 0);
      cmd_im = 2'd1; cmd_im_we = 1; step();

      // R12 halt release by INT
      cmd_ei = 1; step();
      halted = 1; step();
      chk("R12 idle halt", 32'(halt_release), 0);
      int_n = 0; expect_vec(2'd3, 16'h0038, "R12 int"); step();
      chk("R12 release int", 32'(halt_release), 1);
      halted = 0; int_n = 1; step();
      chk("R12 pulse", 32'(halt_release), 0);

      // R12 halt release by NMI with interrupts disabled
      halted = 1; nmi_n = 0; step();
      expect_vec(2'd2, 16'h0066, "R12 nmi"); step();
      chk("R12 release nmi", 32'(halt_release), 1);
      halted = 0; nmi_n = 1; step();

      // R9 acceptance overrides ei, then di
      cmd_ei = 1; step();
      int_n = 0; instr_end = 1; cmd_ei = 1; expect_vec(2'd3, 16'h0038, "R9 override"); step();
      chk("R9 override", 32'(iff1), 0);
      int_n = 1; cmd_ei = 1; step();
      cmd_di = 1; step();
      chk("R9 di iff1", 32'(iff1), 0); chk("R9 di iff2", 32'(iff2), 0);

      // R1 full reset drops pending NMI
      nmi_n = 0; step();
      reset_n = 0; repeat (4) step();
      nmi_n = 1;
      expect_vec(2'd0, 16'h0000, "R2 again");
      reset_n = 1; step();
      instr_end = 1; step();   // no NMI entry expected (R1)
      step();
      chk("R1 scoreboard drained", 32'(sb.size()), 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule